// File: doc/BRIEF.md
# Level-1 Trigger Pulse and Chamber Delay Generator

This block turns a single-cycle accepted-trigger strobe into three timed outputs. The first is a shaped level-1 trigger pulse whose length comes from a 4-bit code with a split encoding. The second and third are chamber triggers for the inner and outer drift-chamber planes. Each of those is launched after its own coarse delay, counted from the start of the level-1 pulse. Timing assumes a 200 MHz clock, so one 5 ns unit is one cycle and one 20 ns delay step is four cycles.

The width code and the two delay codes are captured in the cycle the strobe is accepted. Writes that arrive while a burst is running therefore leave that burst unchanged. A busy flag covers the whole burst, and strobes that arrive during a burst are dropped. Trigger decisions and the output drivers sit outside this block.

Top module: `trig_timing_gen`

## Requirements
- R1: When `trig_in` is high at a clock edge while `busy` is low, `lvl1_trig` and `busy` are both high from the next cycle on. That cycle is called cycle 0 of the burst.
- R2: For a width code below 7, `lvl1_trig` stays high for 21 + code cycles (105 ns + code x 5 ns).
- R3: For a width code of 7 or more, `lvl1_trig` stays high for exactly code cycles (code x 5 ns).
- R4: `mdc12_trig` first goes high in burst cycle 4 x `mdc12_dly`. A delay of 0 makes it rise in cycle 0, together with `lvl1_trig`.
- R5: `mdc34_trig` first goes high in burst cycle 4 x `mdc34_dly`, with the same rule for 0 as R4.
- R6: Each chamber trigger pulse lasts exactly 4 cycles.
- R7: The width and delay codes are sampled only at acceptance. Changing them during a burst does not alter that burst's outputs.
- R8: A strobe on `trig_in` while `busy` is high is ignored. The burst's outputs are unaffected and no new burst starts.
- R9: `busy` stays high from cycle 0 through the last cycle in which any output is high, then drops. A strobe in the first cycle with `busy` low is accepted.
- R10: During reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 200 MHz clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | 1 | Accepted-trigger strobe |
| width_code | input | 4 | Level-1 pulse width code |
| mdc12_dly | input | 5 | Inner-plane chamber delay, 4-cycle steps |
| mdc34_dly | input | 5 | Outer-plane chamber delay, 4-cycle steps |
| lvl1_trig | output | 1 | Shaped level-1 trigger |
| mdc12_trig | output | 1 | Inner-plane chamber trigger |
| mdc34_trig | output | 1 | Outer-plane chamber trigger |
| busy | output | 1 | Burst in progress |

## Verification
The assertions assume that the code inputs carry meaningful values only in the cycle the strobe is accepted. The expected pulse length is latched from `width_code` at that edge and at no other. Strobes in any other cycle may be arbitrary.

The stimulus uses `$urandom` with a fixed seed to draw codes, gaps between bursts, stray strobes placed only where `busy` is high, and scrambled code values during bursts. Directed bursts cover the extreme codes, delays of 0 and 31, and a strobe in the very first idle cycle.

// File: rtl/trig_timing_gen.sv
module trig_timing_gen #(
  parameter int WB         = 4,
  parameter int DB         = 5,
  parameter int STEP_CYC   = 4,
  parameter int MDC_LEN    = 4,
  parameter int BASE_CYC   = 21,
  parameter int SPLIT_CODE = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_in,
  input  logic [WB-1:0] width_code,
  input  logic [DB-1:0] mdc12_dly,
  input  logic [DB-1:0] mdc34_dly,
  output logic          lvl1_trig,
  output logic          mdc12_trig,
  output logic          mdc34_trig,
  output logic          busy
);
  localparam int NCH  = 2;
  localparam int WMAX = (1 << WB) - 1 + BASE_CYC;
  localparam int DMAX = ((1 << DB) - 1) * STEP_CYC + MDC_LEN;
  localparam int EMAX = (WMAX > DMAX) ? WMAX : DMAX;
  localparam int CW   = $clog2(EMAX + 1);
  localparam logic [WB-1:0] SPLIT = WB'(SPLIT_CODE);

  logic [CW-1:0] t_q, wid_q, end_q;
  logic [CW-1:0] dly_q [NCH];
  logic [NCH-1:0] mdc_q;
  logic          lvl1_q, busy_q;

  wire accept = trig_in & ~busy_q;

  wire [CW-1:0] wid_d = (width_code < SPLIT) ? CW'(BASE_CYC) + CW'(width_code)
                                             : CW'(width_code);
  wire [CW-1:0] t_nx  = accept ? '0 : t_q + CW'(1);

  logic [DB-1:0] dcode [NCH];
  logic [CW-1:0] dly_d [NCH];
  logic [CW-1:0] tail_d [NCH];
  logic [CW-1:0] end_d;

  assign dcode[0] = mdc12_dly;
  assign dcode[1] = mdc34_dly;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_ch
      assign dly_d[g]  = CW'(dcode[g]) * CW'(STEP_CYC);
      assign tail_d[g] = dly_d[g] + CW'(MDC_LEN);
    end
  endgenerate

  always_comb begin
    end_d = wid_d;
    for (int i = 0; i < NCH; i++)
      if (tail_d[i] > end_d) end_d = tail_d[i];
  end

  wire done   = busy_q & ~accept & (t_nx == end_q);
  wire busy_d = accept | (busy_q & ~done);

  wire [CW-1:0] s_wid = accept ? wid_d : wid_q;

  logic [NCH-1:0] mdc_d;
  generate
    for (g = 0; g < NCH; g++) begin : g_out
      wire [CW-1:0] s_dly = accept ? dly_d[g] : dly_q[g];
      assign mdc_d[g] = busy_d & (t_nx >= s_dly) & (t_nx < s_dly + CW'(MDC_LEN));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      lvl1_q <= 1'b0;
      mdc_q  <= '0;
      t_q    <= '0;
      wid_q  <= '0;
      end_q  <= '0;
      for (int i = 0; i < NCH; i++) dly_q[i] <= '0;
    end else begin
      busy_q <= busy_d;
      lvl1_q <= busy_d & (t_nx < s_wid);
      mdc_q  <= mdc_d;
      t_q    <= t_nx;
      if (accept) begin
        wid_q <= wid_d;
        end_q <= end_d;
        for (int i = 0; i < NCH; i++) dly_q[i] <= dly_d[i];
      end
    end
  end

  assign lvl1_trig  = lvl1_q;
  assign mdc12_trig = mdc_q[0];
  assign mdc34_trig = mdc_q[1];
  assign busy       = busy_q;
endmodule

module trig_timing_gen_chk #(
  parameter int WB         = 4,
  parameter int MDC_LEN    = 4,
  parameter int BASE_CYC   = 21,
  parameter int SPLIT_CODE = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trig_in,
  input logic [WB-1:0] width_code,
  input logic          lvl1_trig,
  input logic          mdc12_trig,
  input logic          mdc34_trig,
  input logic          busy
);
  localparam int CW = $clog2((1 << WB) + BASE_CYC + 1) + 1;

  logic [CW-1:0] run_l, exp_l;
  logic [2:0]    run_a, run_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_l <= '0; exp_l <= '0; run_a <= '0; run_b <= '0;
    end else begin
      run_l <= lvl1_trig  ? run_l + CW'(1) : '0;
      run_a <= mdc12_trig ? run_a + 3'd1 : '0;
      run_b <= mdc34_trig ? run_b + 3'd1 : '0;
      if (trig_in && !busy)
        exp_l <= (int'(width_code) < SPLIT_CODE) ? CW'(BASE_CYC + int'(width_code))
                                                  : CW'(width_code);
    end
  end

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_in && !busy |=> lvl1_trig && busy);

  p_width_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lvl1_trig) |-> run_l == exp_l);

  p_mdc12_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc12_trig) |-> int'(run_a) == MDC_LEN);

  p_mdc34_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mdc34_trig) |-> int'(run_b) == MDC_LEN);

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl1_trig) |-> $rose(busy));

  p_out_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl1_trig || mdc12_trig || mdc34_trig) |-> busy);

  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(lvl1_trig || mdc12_trig || mdc34_trig));
endmodule

bind trig_timing_gen trig_timing_gen_chk #(
  .WB(WB), .MDC_LEN(MDC_LEN), .BASE_CYC(BASE_CYC), .SPLIT_CODE(SPLIT_CODE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .width_code(width_code),
  .lvl1_trig(lvl1_trig), .mdc12_trig(mdc12_trig), .mdc34_trig(mdc34_trig),
  .busy(busy)
);

// File: tb/test_trig_timing_gen.sv
module test_trig_timing_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_in = 1'b0;
  logic [3:0] width_code = '0;
  logic [4:0] mdc12_dly = '0, mdc34_dly = '0;
  logic       lvl1_trig, mdc12_trig, mdc34_trig, busy;

  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  trig_timing_gen i_trig_timing_gen (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .width_code(width_code),
    .mdc12_dly(mdc12_dly), .mdc34_dly(mdc34_dly), .lvl1_trig(lvl1_trig),
    .mdc12_trig(mdc12_trig), .mdc34_trig(mdc34_trig), .busy(busy)
  );

  function automatic int exp_width(int code);
    return (code < 7) ? 21 + code : code;
  endfunction

  function automatic int exp_end(int code, int a, int b);
    int e = exp_width(code);
    if (4*a + 4 > e) e = 4*a + 4;
    if (4*b + 4 > e) e = 4*b + 4;
    return e;
  endfunction

  task automatic report(bit ok, string req, int cyc, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // Called at a negedge; returns at the negedge of burst cycle "end", where busy has dropped.
  task automatic burst(int code, int a, int b, bit scramble, int retrig_at);
    int e = exp_end(code, a, b);
    int w = exp_width(code);
    bit okl = 1, ok1 = 1, ok2 = 1, okb = 1;
    int cl = 0, c1 = 0, c2 = 0, cb = 0;
    int al = 0, a1 = 0, a2 = 0, ab = 0;
    string sfx = scramble ? " R7" : "";
    width_code = 4'(code); mdc12_dly = 5'(a); mdc34_dly = 5'(b);
    trig_in = 1'b1;
    @(negedge clk);
    for (int i = 0; i <= e; i++) begin
      bit xl = (i < w);
      bit x1 = (i >= 4*a) && (i < 4*a + 4);
      bit x2 = (i >= 4*b) && (i < 4*b + 4);
      bit xb = (i < e);
      if (okl && lvl1_trig  !== xl) begin okl = 0; cl = i; al = int'(lvl1_trig); end
      if (ok1 && mdc12_trig !== x1) begin ok1 = 0; c1 = i; a1 = int'(mdc12_trig); end
      if (ok2 && mdc34_trig !== x2) begin ok2 = 0; c2 = i; a2 = int'(mdc34_trig); end
      if (okb && busy       !== xb) begin okb = 0; cb = i; ab = int'(busy); end
      if (scramble) begin
        width_code = 4'($urandom); mdc12_dly = 5'($urandom); mdc34_dly = 5'($urandom);
      end
      trig_in = (i == retrig_at);
      if (i < e) @(negedge clk);
    end
    report(okl, {(code < 7) ? "R1 R2" : "R1 R3", sfx, (retrig_at >= 0) ? " R8" : ""},
           cl, al, okl ? 0 : 1 - al);
    report(ok1, {"R4 R6", sfx}, c1, a1, ok1 ? 0 : 1 - a1);
    report(ok2, {"R5 R6", sfx}, c2, a2, ok2 ? 0 : 1 - a2);
    report(okb, {"R9", (retrig_at >= 0) ? " R8" : ""}, cb, ab, okb ? 0 : 1 - ab);
  endtask

  task automatic idle(int n);
    trig_in = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    trig_in = 1'b1;
    repeat (3) @(negedge clk);
    report({lvl1_trig, mdc12_trig, mdc34_trig, busy} == 4'b0000, "R10", 0,
           int'({lvl1_trig, mdc12_trig, mdc34_trig, busy}), 0);
    trig_in = 1'b0;
    rst_n = 1'b1;
    idle(2);

    burst(0, 0, 0, 0, -1);   idle(1);
    burst(6, 1, 0, 0, -1);   idle(1);
    burst(7, 0, 1, 0, -1);   idle(1);
    burst(15, 31, 31, 0, -1); idle(1);
    burst(3, 31, 2, 0, 0);   idle(1);
    burst(10, 2, 5, 0, 7);
    burst(1, 0, 3, 0, -1);
    burst(9, 4, 0, 1, 3);    idle(2);
    burst(15, 0, 0, 1, 14);

    for (int n = 0; n < 200; n++) begin
      int code = int'($urandom_range(0, 15));
      int a = int'($urandom_range(0, 31));
      int b = int'($urandom_range(0, 31));
      int e = exp_end(code, a, b);
      int r = ($urandom_range(0, 2) == 0) ? int'($urandom_range(0, e - 1)) : -1;
      burst(code, a, b, 1'($urandom), r);
      idle(int'($urandom_range(0, 3)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule